// File: doc/BRIEF.md
# Two-Wire Serial Target with Broadcast Reset

This block is the serial front end of a register-based peripheral on a two-wire bus. The clock line is only ever observed. The data line is only ever pulled low or released, through a single pull-low enable that drives an external open-drain pad. Both lines pass through synchronisers into the system clock domain. Start and stop conditions and clock edges are all detected in that domain.

After a start condition the block shifts in an address byte: a 7-bit address, MSB first, then a direction bit. If the address matches its own, the block acknowledges it. It then either hands each received byte to a register file through a one-cycle write strobe, or fetches bytes from the register file through a one-cycle read request and shifts them out.

The block also recognises the broadcast reset: address byte 0x00 with the write direction, followed by data byte 0x06. It acknowledges both bytes and then emits a one-cycle reset pulse, which the surrounding chip uses to return to its power-up state.

Top module: `i2cResetSlave`

## Requirements
- R1: The clock line is an input only. The data line is driven only through `sdaPullLow` (1 = pull low, 0 = release). After reset `sdaPullLow`, `wrValid`, `rdReq` and `gcReset` are all 0.
- R2: A stop condition (data rising while the clock is high) returns the block to idle with the data line released. Bytes clocked after a stop and without a new start are not acknowledged and produce no write strobe.
- R3: Bits are sampled on rising clock-line edges, MSB first. The address byte is the 7-bit address followed by the direction bit (1 = read). When the address equals `DEV_ADDR` (default 0x48), `sdaPullLow` is 1 throughout the high phase of the ninth clock.
- R4: A non-matching address, including 0x00 with the read bit, is not acknowledged. The block then ignores all traffic until the next start, so following bytes get no acknowledge and no `wrValid` or `rdReq`.
- R5: In a write to the matched address, every data byte is acknowledged. After its eighth bit, the byte appears on `wrData` with a `wrValid` pulse exactly one cycle long.
- R6: In a read, a one-cycle `rdReq` captures `rdData`. That byte is shifted out MSB first, with `sdaPullLow` equal to the inverse of the bit being sent. The line is released for the ninth clock.
- R7: An acknowledge from the master during a read (data low on the ninth clock) fetches and sends the next byte. A not-acknowledge ends the transfer: the line stays released and no further `rdReq` is issued until the next start.
- R8: Address byte 0x00 with the write bit is acknowledged, and a following data byte 0x06 is also acknowledged. Exactly one `gcReset` pulse, one cycle long, follows at the end of that acknowledge clock. Broadcast bytes never raise `wrValid`.
- R9: After the broadcast address, any data byte other than 0x06 is not acknowledged and gives no `gcReset`.
- R10: A start condition in the middle of a byte discards the partial byte and restarts address reception, so a following transfer behaves as if it were the first.
- R11: `sdaPullLow` never changes while the synchronised clock line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| wrValid | output | 1 | One-cycle strobe: `wrData` holds a received byte |
| wrData | output | 8 | Last received data byte |
| rdReq | output | 1 | One-cycle request; `rdData` is captured in the same cycle |
| rdData | input | 8 | Byte supplied by the register file for reading |
| gcReset | output | 1 | One-cycle internal reset pulse after a broadcast reset |

## Verification
The bench builds the block with its default parameters: address 0x48, two synchroniser stages and reset code 0x06. With the bus clock at one sixteenth of the system clock, the bench sweeps all 128 write addresses, so every match and mismatch of the decoder is checked, including the broadcast address. It also sweeps all 256 data bytes after the broadcast address, which proves that only 0x06 raises the reset pulse. A long burst write, a multi-byte read ending in a not-acknowledge, traffic after a stop, and a start in the middle of a byte cover the remaining sequencing paths.

// File: rtl/i2cSlavePkg.sv
package i2cSlavePkg;

  typedef struct packed {
    logic rxShift;
    logic cntInc;
    logic cntClr;
    logic txLoad;
    logic txShift;
    logic pullAck;
    logic pullRelease;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } slvState_t;

endpackage

// File: rtl/i2cSlaveDatapath.sv
module i2cSlaveDatapath
  import i2cSlavePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctrlStrobes_t      st,
  input  logic [BYTE_W-1:0] rdData,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              sdaPull
);

  logic [SYNC_STAGES-1:0] sclChain;
  logic [SYNC_STAGES-1:0] sdaChain;
  logic sclS, sdaS, sclD, sdaD;
  logic [BYTE_W-1:0] txByte;

  // synchroniser chains, reset to the idle-high bus level
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= sclIn;
          sdaChain <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
          sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclChain[SYNC_STAGES-1];
  assign sdaS = sdaChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign sdaBit   = sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
    end else begin
      if (st.rxShift) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (st.cntClr) bitCnt <= '0;
      else if (st.cntInc) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByte  <= '0;
      sdaPull <= 1'b0;
    end else if (st.pullRelease) begin
      sdaPull <= 1'b0;
    end else if (st.pullAck) begin
      sdaPull <= 1'b1;
    end else if (st.txLoad) begin
      txByte  <= rdData;
      sdaPull <= ~rdData[BYTE_W-1];
    end else if (st.txShift) begin
      txByte  <= {txByte[BYTE_W-2:0], 1'b0};
      sdaPull <= ~txByte[BYTE_W-2];
    end
  end

  // R3
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));

  // R11
  pull_stable_scl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclD) |-> $stable(sdaPull));

endmodule

// File: rtl/i2cSlaveControl.sv
module i2cSlaveControl
  import i2cSlavePkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-2:0] DEV_ADDR = 7'h48,
  parameter logic [BYTE_W-1:0] GC_CODE = 8'h06,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [CNT_W-1:0]  bitCnt,
  output ctrlStrobes_t      st,
  output logic              wrValid,
  output logic              rdReq,
  output logic              gcReset
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  slvState_t state, nextState;
  logic gcMode, gcArm, masterAck;
  logic wrPulse, gcPulse, byteDone, addrHit, gcHit;

  assign byteDone = sclFall && (bitCnt == FULL);
  assign addrHit  = (rxByte[BYTE_W-1:1] == DEV_ADDR);
  assign gcHit    = (rxByte == '0);

  always_comb begin
    st        = '0;
    nextState = state;
    wrPulse   = 1'b0;
    gcPulse   = 1'b0;
    if (startDet) begin
      nextState      = ST_ADDR;
      st.cntClr      = 1'b1;
      st.pullRelease = 1'b1;
    end else if (stopDet) begin
      nextState      = ST_IDLE;
      st.cntClr      = 1'b1;
      st.pullRelease = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (sclRise && bitCnt < FULL) begin
            st.rxShift = 1'b1;
            st.cntInc  = 1'b1;
          end
          if (byteDone) begin
            st.cntClr = 1'b1;
            if (state == ST_ADDR) begin
              if (addrHit || gcHit) begin
                st.pullAck = 1'b1;
                nextState  = ST_ADDR_ACK;
              end else begin
                nextState = ST_IDLE;
              end
            end else if (gcMode) begin
              if (rxByte == GC_CODE) begin
                st.pullAck = 1'b1;
                nextState  = ST_WDATA_ACK;
              end else begin
                nextState = ST_IDLE;
              end
            end else begin
              st.pullAck = 1'b1;
              wrPulse    = 1'b1;
              nextState  = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (rxByte[0]) begin
              st.txLoad = 1'b1;
              nextState = ST_RDATA;
            end else begin
              st.pullRelease = 1'b1;
              nextState      = ST_WDATA;
            end
          end
        end
        ST_WDATA_ACK: begin
          if (sclFall) begin
            st.pullRelease = 1'b1;
            if (gcArm) begin
              gcPulse   = 1'b1;
              nextState = ST_IDLE;
            end else begin
              nextState = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (sclRise) st.cntInc = 1'b1;
          if (sclFall) begin
            if (bitCnt == FULL) begin
              st.cntClr      = 1'b1;
              st.pullRelease = 1'b1;
              nextState      = ST_RDATA_ACK;
            end else begin
              st.txShift = 1'b1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (sclFall) begin
            if (masterAck) begin
              st.txLoad = 1'b1;
              nextState = ST_RDATA;
            end else begin
              nextState = ST_IDLE;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign rdReq = st.txLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wrValid   <= 1'b0;
      gcReset   <= 1'b0;
      gcMode    <= 1'b0;
      gcArm     <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state   <= nextState;
      wrValid <= wrPulse;
      gcReset <= gcPulse;
      if (startDet || stopDet || state == ST_IDLE) begin
        gcMode <= 1'b0;
        gcArm  <= 1'b0;
      end else begin
        if (state == ST_ADDR && byteDone) gcMode <= gcHit;
        if (state == ST_WDATA && byteDone && gcMode && rxByte == GC_CODE) gcArm <= 1'b1;
      end
      if (state == ST_RDATA_ACK && sclRise) masterAck <= ~sdaBit;
    end
  end

  // R5
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  // R8
  gc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    gcReset |=> !gcReset);

  // R10
  restart_to_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR));

  // R4
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> !wrValid);

endmodule

// File: rtl/i2cResetSlave.sv
module i2cResetSlave
  import i2cSlavePkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] GC_CODE = 8'h06
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output logic       wrValid,
  output logic [7:0] wrData,
  output logic       rdReq,
  input  logic [7:0] rdData,
  output logic       gcReset
);

  localparam int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W + 1);

  ctrlStrobes_t strobes;
  logic sclRise, sclFall, startDet, stopDet, sdaBit;
  logic [BYTE_W-1:0] rxByte;
  logic [CNT_W-1:0] bitCnt;

  i2cSlaveDatapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .BYTE_W(BYTE_W)
  ) dp (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .st(strobes),
    .rdData(rdData),
    .sclRise(sclRise),
    .sclFall(sclFall),
    .startDet(startDet),
    .stopDet(stopDet),
    .sdaBit(sdaBit),
    .rxByte(rxByte),
    .bitCnt(bitCnt),
    .sdaPull(sdaPullLow)
  );

  i2cSlaveControl #(
    .BYTE_W(BYTE_W),
    .DEV_ADDR(DEV_ADDR),
    .GC_CODE(GC_CODE)
  ) ctl (
    .clk(clk),
    .rstN(rstN),
    .sclRise(sclRise),
    .sclFall(sclFall),
    .startDet(startDet),
    .stopDet(stopDet),
    .sdaBit(sdaBit),
    .rxByte(rxByte),
    .bitCnt(bitCnt),
    .st(strobes),
    .wrValid(wrValid),
    .rdReq(rdReq),
    .gcReset(gcReset)
  );

  assign wrData = rxByte;

endmodule

// File: tb/i2cResetSlave_test.sv
`timescale 1ns/1ps
module i2cResetSlave_test;

  localparam int Q = 4;
  localparam logic [6:0] MY_ADDR = 7'h48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic mSda = 1'b1;
  logic sdaIn;
  logic sdaPullLow, wrValid, rdReq, gcReset;
  logic [7:0] wrData, rdData;

  int checks = 0, errors = 0;
  int wrCount = 0, gcCount = 0, rdCount = 0, r11Viol = 0;
  logic [7:0] lastWr = '0;
  logic prevScl = 1'b1, prevPull = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign sdaIn = mSda & ~sdaPullLow;

  i2cResetSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaPullLow(sdaPullLow), .wrValid(wrValid), .wrData(wrData),
    .rdReq(rdReq), .rdData(rdData), .gcReset(gcReset)
  );

  function automatic logic [7:0] rdModel(int k);
    return 8'((k * 37) ^ 165);
  endfunction

  assign rdData = rdModel(rdCount);

  always @(posedge clk) begin
    if (wrValid) begin
      wrCount <= wrCount + 1;
      lastWr  <= wrData;
    end
    if (gcReset) gcCount <= gcCount + 1;
    if (rdReq) rdCount <= rdCount + 1;
  end

  // R11: external observation of pull changes while the line is held high
  always @(negedge clk) begin
    if (rstN && sclIn && prevScl && sdaPullLow !== prevPull) r11Viol = r11Viol + 1;
    prevScl  = sclIn;
    prevPull = sdaPullLow;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qd();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; qd();
    sclIn = 1'b1; qd();
    mSda = 1'b0; qd();
    sclIn = 1'b0; qd();
  endtask

  task automatic busStop();
    mSda = 1'b0; qd();
    sclIn = 1'b1; qd();
    mSda = 1'b1; qd();
  endtask

  task automatic sendBit(logic b, output logic seen);
    mSda = b; qd();
    sclIn = 1'b1; qd();
    seen = sdaIn; qd();
    sclIn = 1'b0; qd();
  endtask

  task automatic sendByte(logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(b[i], s);
    sendBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(logic giveAck, output logic [7:0] val);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      sendBit(1'b1, s);
      val[i] = s;
    end
    sendBit(~giveAck, s);
  endtask

  initial begin
    logic ack;
    logic [7:0] got;
    int w0, g0, r0, expIdx;

    repeat (5) @(negedge clk);
    chk("R1 reset pull", sdaPullLow, 0);
    chk("R1 reset wrValid", wrValid, 0);
    chk("R1 reset gcReset", gcReset, 0);
    chk("R1 reset rdReq", rdReq, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R3/R4: sweep every write address
    for (int a = 0; a < 128; a++) begin
      w0 = wrCount;
      busStart();
      sendByte({a[6:0], 1'b0}, ack);
      chk($sformatf("R3 R4 ack addr %0h", a), ack, (a == MY_ADDR || a == 0));
      busStop();
      chk("R4 no write on address", wrCount - w0, 0);
    end

    // R4: mismatch ignores following data; broadcast with read bit refused
    w0 = wrCount;
    busStart();
    sendByte({7'h49, 1'b0}, ack);
    chk("R4 mismatch nack", ack, 0);
    sendByte(8'h55, ack);
    chk("R4 data ignored ack", ack, 0);
    busStop();
    chk("R4 data ignored write", wrCount - w0, 0);
    r0 = rdCount;
    busStart();
    sendByte(8'h01, ack);
    chk("R4 broadcast read nack", ack, 0);
    busStop();
    chk("R4 broadcast read no rdReq", rdCount - r0, 0);

    // R5: burst write of 64 bytes
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    chk("R5 addr ack", ack, 1);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] d;
      d = 8'((i * 73) + 11);
      w0 = wrCount;
      sendByte(d, ack);
      chk("R5 data ack", ack, 1);
      chk("R5 wrValid count", wrCount - w0, 1);
      chk("R5 wrData", lastWr, d);
    end
    busStop();
    chk("R2 released after stop", sdaPullLow, 0);

    // R2: bytes without a start after stop
    w0 = wrCount;
    sendByte(8'h90, ack);
    chk("R2 no ack without start", ack, 0);
    chk("R2 no write without start", wrCount - w0, 0);
    busStop();

    // R6/R7: read four bytes, NACK the last
    expIdx = rdCount;
    busStart();
    sendByte({MY_ADDR, 1'b1}, ack);
    chk("R3 read addr ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      readByte(i < 3, got);
      chk($sformatf("R6 read byte %0d", i), got, rdModel(expIdx));
      expIdx++;
    end
    r0 = rdCount;
    chk("R7 rdReq count", r0, expIdx);
    readByte(1'b1, got);
    chk("R7 released after nack", got, 8'hFF);
    chk("R7 no rdReq after nack", rdCount - r0, 0);
    busStop();

    // R8/R9: sweep every broadcast data byte
    for (int d = 0; d < 256; d++) begin
      g0 = gcCount;
      w0 = wrCount;
      busStart();
      sendByte(8'h00, ack);
      chk("R8 broadcast addr ack", ack, 1);
      sendByte(d[7:0], ack);
      chk($sformatf("R8 R9 ack data %0h", d), ack, (d == 6));
      busStop();
      chk($sformatf("R8 R9 gcReset data %0h", d), gcCount - g0, (d == 6));
      chk("R8 no write on broadcast", wrCount - w0, 0);
    end

    // R10: start in the middle of a byte
    w0 = wrCount;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    for (int i = 0; i < 4; i++) sendBit(i[0], ack);
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    chk("R10 restart addr ack", ack, 1);
    sendByte(8'h3C, ack);
    chk("R10 data ack", ack, 1);
    busStop();
    chk("R10 one write", wrCount - w0, 1);
    chk("R10 write value", lastWr, 8'h3C);

    chk("R11 pull stable while clock high", r11Viol, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule